// File: doc/BRIEF.md
# Adaptive Huffman Nibble Encoder

This block turns a stream of 4-bit symbols into variable-length prefix codes. Encoder and decoder both build the same binary code tree while the stream passes, so no code table is ever sent. A symbol that has not been seen yet goes out as the path to the empty "not yet transferred" (NYT) placeholder, followed by its raw value. A symbol that already has a leaf goes out as the path to that leaf only.

The tree holds one leaf per symbol seen since reset, up to 16. The leaves hang off a chain of internal nodes, and the NYT placeholder sits at the bottom of that chain. After each symbol the encoder adds one to the leaf's count. It then recomputes the internal weights from the affected node up to the root, one node per clock. At each node, when the left child outweighs the right child, the two subtrees change places. While this update runs the input handshake is closed. Codes leave left-aligned on a 20-bit bus, with a length field and a one-cycle strobe. A downstream packer takes them from there.

Top module: `ahn_encoder`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) empties the tree to a lone NYT root of weight 0 and clears the record of seen symbols. After reset `inReady` is 1 and `outValid` is 0.
- R2: A symbol is taken at a rising edge where `inValid` and `inReady` are both 1. From the next cycle `inReady` stays 0 until the tree update for that symbol is over. While it is 0, `inSym` and `inValid` have no effect.
- R3: For each symbol taken, `outValid` is high for exactly one cycle, three rising edges after the edge that took the symbol. Lookup and code emission are separate clocked stages.
- R4: The first symbol after reset produces a code of length 4 that holds the raw symbol value, most significant bit first.
- R5: A symbol never seen before produces the branch bits from the root to the NYT node, followed by its 4 raw bits. Its length is the NYT depth plus 4. The NYT node then splits into a new NYT node of weight 0 on the left (bit 0) and the new symbol leaf of weight 1 on the right (bit 1).
- R6: A symbol already in the tree produces only the branch bits from the root to its leaf, and its leaf weight grows by 1.
- R7: After each symbol, every internal node from the parent of the touched leaf up to the root takes the sum of its two children's weights, working bottom-up. At each such node, if the left weight is strictly greater than the right weight, the two children swap sides along with their subtrees; equal weights swap nothing. A left branch is coded 0 and a right branch 1.
- R8: `outCode` is left-aligned, with the first code bit at bit 19. Every bit below the last code bit is 0. `outLen` lies between 1 and 19, and reaches 19 for the sixteenth distinct symbol when the first fifteen were never repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input symbol offered |
| inSym | input | 4 | Input symbol value |
| inReady | output | 1 | Encoder can take a symbol |
| outValid | output | 1 | One-cycle strobe for a code word |
| outCode | output | 20 | Code word, left-aligned |
| outLen | output | 5 | Number of valid code bits |

## Verification
The hardest state to reach is a tree with a deep chain whose orientation bits have been flipped several times by swaps. Only then does a leaf's code depend on the history of swaps higher up. The stimulus gets there in two ways. One run sends all sixteen values once, to reach the deepest NYT path. Other long random and skewed runs repeat a few symbols heavily, which makes leaf weights overtake whole subtrees. A behavioural tree model in the bench, built from linked nodes, predicts every code, its length and its cycle. Symbols are held on the input during busy periods, so an early acceptance would show up as a shifted stream.

// File: rtl/ahn_pkg.sv
package ahn_pkg;
  // strobes issued by the control FSM to the datapath, one per phase
  typedef struct packed {
    logic capture;  // latch incoming symbol
    logic lookup;   // register presence and leaf position
    logic emit;     // form code, insert or bump leaf
    logic update;   // recompute one internal node and maybe swap
  } ctlStrobe_t;
endpackage

// File: rtl/ahn_ctrl.sv
module ahn_ctrl
  import ahn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       updLast,
  output logic       inReady,
  output ctlStrobe_t strobe
);
  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_EMIT, S_UPD} state_t;
  state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (inValid) state <= S_LOOK;
        S_LOOK: state <= S_EMIT;
        S_EMIT: state <= S_UPD;
        S_UPD:  if (updLast) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    inReady        = (state == S_IDLE);
    strobe.capture = inReady && inValid;
    strobe.lookup  = (state == S_LOOK);
    strobe.emit    = (state == S_EMIT);
    strobe.update  = (state == S_UPD);
  end
endmodule

// File: rtl/ahn_dpath.sv
module ahn_dpath
  import ahn_pkg::*;
#(
  parameter int SYM_W  = 4,
  parameter int WGT_W  = 16,
  localparam int NSYM   = 1 << SYM_W,
  localparam int CODE_W = NSYM + SYM_W,
  localparam int LEN_W  = $clog2(CODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobe,
  input  logic [SYM_W-1:0]  inSym,
  output logic              updLast,
  output logic              outValid,
  output logic [CODE_W-1:0] outCode,
  output logic [LEN_W-1:0]  outLen
);
  localparam int CNT_W = $clog2(NSYM + 1);

  // chain slot i: internal node i with one leaf child and one chain child
  logic [SYM_W-1:0] leafSym [NSYM];
  logic [WGT_W-1:0] leafW   [NSYM];
  logic [WGT_W-1:0] subW    [NSYM];
  logic [NSYM-1:0]  leafRight;   // 1: leaf on the right branch
  logic [NSYM-1:0]  present;     // indexed by symbol value
  logic [CNT_W-1:0] count;       // leaves in use == NYT depth

  logic [SYM_W-1:0] symReg, posReg, cursor;
  logic             hitReg;

  // ---- lookup stage ----
  logic [NSYM-1:0]  matchVec;
  logic [SYM_W-1:0] matchPos;

  for (genvar g = 0; g < NSYM; g++) begin : g_match
    assign matchVec[g] = (CNT_W'(g) < count) && (leafSym[g] == symReg);
  end

  always_comb begin
    matchPos = '0;
    for (int i = 0; i < NSYM; i++)
      if (matchVec[i]) matchPos = SYM_W'(i);
  end

  // ---- emit stage: code formation ----
  logic [CODE_W-1:0] codeNext;
  logic [LEN_W-1:0]  lenNext;
  logic [CNT_W-1:0]  pathLen;

  always_comb begin
    codeNext = '0;
    pathLen  = hitReg ? {1'b0, posReg} : count;
    for (int j = 0; j < NSYM; j++)
      if (CNT_W'(j) < pathLen) codeNext[CODE_W-1-j] = ~leafRight[j];
    if (hitReg) begin
      codeNext[CODE_W-1-int'(posReg)] = leafRight[posReg];
      lenNext = LEN_W'(posReg) + LEN_W'(1);
    end else begin
      codeNext = codeNext | ({symReg, {NSYM{1'b0}}} >> count);
      lenNext  = LEN_W'(count) + LEN_W'(SYM_W);
    end
  end

  // ---- update stage: one internal node per cycle ----
  logic [CNT_W-1:0] nextIdx;
  logic [WGT_W-1:0] chainW, leafWc, leftW, rightW;
  logic             doSwap;

  always_comb begin
    nextIdx = {1'b0, cursor} + CNT_W'(1);
    chainW  = (nextIdx < count) ? subW[nextIdx[SYM_W-1:0]] : '0;
    leafWc  = leafW[cursor];
    leftW   = leafRight[cursor] ? chainW : leafWc;
    rightW  = leafRight[cursor] ? leafWc : chainW;
    doSwap  = leftW > rightW;
  end

  assign updLast = (cursor == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      present   <= '0;
      leafRight <= '0;
      symReg    <= '0;
      posReg    <= '0;
      hitReg    <= 1'b0;
      cursor    <= '0;
      outValid  <= 1'b0;
      outCode   <= '0;
      outLen    <= '0;
      for (int i = 0; i < NSYM; i++) begin
        leafSym[i] <= '0;
        leafW[i]   <= '0;
        subW[i]    <= '0;
      end
    end else begin
      outValid <= 1'b0;
      if (strobe.capture) symReg <= inSym;
      if (strobe.lookup) begin
        hitReg <= present[symReg];
        posReg <= matchPos;
      end
      if (strobe.emit) begin
        outValid <= 1'b1;
        outCode  <= codeNext;
        outLen   <= lenNext;
        if (hitReg) begin
          leafW[posReg] <= leafW[posReg] + WGT_W'(1);
          cursor        <= posReg;
        end else begin
          leafSym[count[SYM_W-1:0]]   <= symReg;
          leafW[count[SYM_W-1:0]]     <= WGT_W'(1);
          leafRight[count[SYM_W-1:0]] <= 1'b1;
          present[symReg]             <= 1'b1;
          count                       <= count + CNT_W'(1);
          cursor                      <= count[SYM_W-1:0];
        end
      end
      if (strobe.update) begin
        subW[cursor] <= leafWc + chainW;
        if (doSwap) leafRight[cursor] <= ~leafRight[cursor];
        if (cursor != '0) cursor <= cursor - SYM_W'(1);
      end
    end
  end
endmodule

// File: rtl/ahn_encoder.sv
module ahn_encoder
  import ahn_pkg::*;
#(
  parameter int SYM_W  = 4,
  parameter int WGT_W  = 16,
  localparam int NSYM   = 1 << SYM_W,
  localparam int CODE_W = NSYM + SYM_W,
  localparam int LEN_W  = $clog2(CODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [SYM_W-1:0]  inSym,
  output logic              inReady,
  output logic              outValid,
  output logic [CODE_W-1:0] outCode,
  output logic [LEN_W-1:0]  outLen
);
  ctlStrobe_t strobe;
  logic       updLast;

  ahn_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .updLast(updLast),
    .inReady(inReady), .strobe(strobe)
  );

  ahn_dpath #(.SYM_W(SYM_W), .WGT_W(WGT_W)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .inSym(inSym),
    .updLast(updLast), .outValid(outValid), .outCode(outCode), .outLen(outLen)
  );
endmodule

// File: rtl/ahn_encoder_chk.sv
module ahn_encoder_chk #(
  parameter int SYM_W  = 4,
  localparam int NSYM   = 1 << SYM_W,
  localparam int CODE_W = NSYM + SYM_W,
  localparam int LEN_W  = $clog2(CODE_W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic [CODE_W-1:0] outCode,
  input logic [LEN_W-1:0]  outLen
);
  logic acc;
  logic firstFlag;
  assign acc = inValid && inReady && !rst;

  always_ff @(posedge clk) begin
    if (rst) firstFlag <= 1'b1;
    else if (outValid) firstFlag <= 1'b0;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!outValid && inReady));
  // R2
  busy_closed_chk: assert property (@(posedge clk) disable iff (rst) $past(acc) |-> !inReady);
  // R3
  emit_latency_chk: assert property (@(posedge clk) disable iff (rst) outValid == $past(acc, 3));
  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst) outValid |=> !outValid);
  // R4
  first_len_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && firstFlag) |-> (outLen == LEN_W'(SYM_W)));
  // R8
  tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ((outCode << outLen) == CODE_W'(0)));
  // R8
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outLen >= LEN_W'(1) && outLen < LEN_W'(CODE_W)));
endmodule

bind ahn_encoder ahn_encoder_chk #(.SYM_W(SYM_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outCode(outCode), .outLen(outLen)
);

// File: tb/ahn_encoder_test.sv
`timescale 1ns/1ps
module ahn_encoder_test;
  localparam int CODE_W = 20;
  localparam int LEN_W  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [3:0] inSym = '0;
  logic inReady, outValid;
  logic [CODE_W-1:0] outCode;
  logic [LEN_W-1:0]  outLen;

  always #4 clk = ~clk;

  ahn_encoder uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSym(inSym),
    .inReady(inReady), .outValid(outValid), .outCode(outCode), .outLen(outLen)
  );

  int total = 0, bad = 0, cyc = 0, maxLen = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural tree: linked nodes
  int nPar[64], nL[64], nR[64], nW[64];
  int nNodes, nyt, nSeen;
  int leafOf[16];

  logic [CODE_W-1:0] qCode[$];
  int qLen[$], qCyc[$];
  string qTag[$];

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    nNodes = 1; nyt = 0; nSeen = 0;
    nPar[0] = -1; nL[0] = -1; nR[0] = -1; nW[0] = 0;
    for (int i = 0; i < 16; i++) leafOf[i] = -1;
  endtask

  task automatic pathTo(int node, ref bit bq[$]);
    int n, p;
    bq.delete();
    n = node;
    while (nPar[n] != -1) begin
      p = nPar[n];
      bq.push_front(nR[p] == n);
      n = p;
    end
  endtask

  task automatic modelStep(int sym, output logic [CODE_W-1:0] code, output int len, output string tag);
    bit bq[$];
    int start, n, t;
    if (leafOf[sym] == -1) begin
      pathTo(nyt, bq);
      for (int b = 3; b >= 0; b--) bq.push_back(sym[b]);
      tag = (nSeen == 0) ? "R4" : "R5";
      start = nyt;
      nL[start] = nNodes; nR[start] = nNodes + 1;
      nPar[nNodes] = start; nL[nNodes] = -1; nR[nNodes] = -1; nW[nNodes] = 0;
      nPar[nNodes+1] = start; nL[nNodes+1] = -1; nR[nNodes+1] = -1; nW[nNodes+1] = 1;
      nyt = nNodes; leafOf[sym] = nNodes + 1; nNodes += 2; nSeen++;
    end else begin
      pathTo(leafOf[sym], bq);
      tag = "R6_R7";
      nW[leafOf[sym]]++;
      start = nPar[leafOf[sym]];
    end
    n = start;
    while (n != -1) begin
      nW[n] = nW[nL[n]] + nW[nR[n]];
      if (nW[nL[n]] > nW[nR[n]]) begin t = nL[n]; nL[n] = nR[n]; nR[n] = t; end
      n = nPar[n];
    end
    code = '0;
    len = bq.size();
    for (int k = 0; k < len; k++) code[CODE_W-1-k] = bq[k];
  endtask

  // output monitor: compare every strobe against the model
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (qCode.size() == 0) begin
        check(1'b0, "R3", "unexpected strobe", 1, 0);
      end else begin
        logic [CODE_W-1:0] ec; int el, ecy; string tg;
        ec = qCode.pop_front(); el = qLen.pop_front(); ecy = qCyc.pop_front(); tg = qTag.pop_front();
        check(outCode == ec, tg, "code", outCode, ec);
        check(int'(outLen) == el, tg, "length", outLen, el);
        check(cyc == ecy, "R3", "strobe cycle", cyc, ecy);
        check((outCode << outLen) == '0, "R8", "tail bits", outCode, ec);
        if (int'(outLen) > maxLen) maxLen = outLen;
      end
    end
  end

  task automatic send(int sym, int gap);
    logic [CODE_W-1:0] c; int l; string tg;
    repeat (gap) @(negedge clk);
    inValid = 1'b1; inSym = 4'(sym);
    while (!inReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    modelStep(sym, c, l, tg);
    qCode.push_back(c); qLen.push_back(l); qCyc.push_back(cyc + 2); qTag.push_back(tg);
    check(inReady == 1'b0, "R2", "ready after accept", inReady, 0);
    inValid = 1'b0;
    inSym = 4'(sym ^ 4'hF);   // value seen while busy must not matter
  endtask

  task automatic drain();
    int n = 0;
    while ((qCode.size() != 0 || !inReady) && n < 200) begin @(negedge clk); n++; end
    check(qCode.size() == 0, "R3", "pending codes", qCode.size(), 0);
  endtask

  task automatic doReset(bit validDuring);
    @(negedge clk);
    rst = 1'b1; inValid = validDuring; inSym = 4'h7;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; inValid = 1'b0;
    modelReset();
    qCode.delete(); qLen.delete(); qCyc.delete(); qTag.delete();
    check(inReady == 1'b1, "R1", "ready after reset", inReady, 1);
    check(outValid == 1'b0, "R1", "strobe after reset", outValid, 0);
  endtask

  initial begin
    modelReset();
    doReset(1'b0);
    // small hand pattern: 1010,1011,1011,1010
    send(10, 0); send(11, 0); send(11, 0); send(10, 0);
    drain();
    // every value once: deepest NYT path reaches length 19 (R8)
    doReset(1'b1);
    for (int s = 0; s < 16; s++) send(s, s % 2);
    drain();
    check(maxLen == 19, "R8", "max length", maxLen, 19);
    for (int s = 15; s >= 0; s--) send(s, 0);
    drain();
    // degenerate: one value repeated
    doReset(1'b0);
    for (int i = 0; i < 40; i++) send(5, 0);
    drain();
    // uniform random with random gaps
    doReset(1'b0);
    for (int i = 0; i < 500; i++) send(int'($urandom_range(15, 0)), int'($urandom_range(2, 0)));
    drain();
    // skewed random: few heavy symbols force swaps high in the chain
    doReset(1'b0);
    for (int i = 0; i < 500; i++) begin
      int r = int'($urandom_range(99, 0));
      send((r < 70) ? (r % 3) : (r % 16), 0);
    end
    drain();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule